// File: doc/BRIEF.md
# Redundant-Digit Decimal Ripple Adder

This block adds two packed decimal operands of `DIGITS` digits each, plus a carry input. Each 4-bit digit uses an extended decimal code: the plain values 0000 to 1001 stand for 0 to 9, and the two spare codes 1110 and 1111 are also accepted as 8 and 9. Every digit cell looks at the weight-8, weight-4 and weight-2 bits of both inputs. From these it decides whether to fold a +6 correction into a 4-bit binary addition. A decimal carry ripples from the least significant digit upward.

The sum is left in the same extended code. Because of this, a result can go straight into the next adder of a multi-operand tree with no fix-up step between levels. Turning the result into plain decimal is left to a single step after the last level, which is not part of this block. The sum and the carry-out are captured in an output register whose load enable is written out.

Top module: `bcdx_adder`

## Requirements
- R1: Each input digit takes one of the codes 0000 to 1001 (values 0 to 9), 1110 (value 8) or 1111 (value 9). The codes 1010 to 1101 never occur.
- R2: In the cycle after `en` is high at a rising edge, the result is correct. Decode every digit of `sum` (1110 reads as 8, 1111 reads as 9, all other codes read as their binary value) and weight digit i by 10^i. Add `cout` times 10^DIGITS. This total equals the decoded value of `a`, plus the decoded value of `b`, plus `cin`.
- R3: Every digit of `sum` is one of the codes allowed in R1.
- R4: A `sum` digit comes out as 1110 or 1111 only when that position's inputs, with bit 0 cleared and read at their decimal value, add up to exactly 8.
- R5: A digit position that passes a carry to the next position (its decimal value plus the incoming carry is at least 10) produces a plain code 0000 to 1001.
- R6: The carry runs from digit 0, which takes `cin`, to digit DIGITS-1, which drives `cout`. An all-nines operand plus zero plus `cin`=1 gives all zeros and `cout`=1.
- R7: While `en` is low, `sum` and `cout` hold their values, whatever the inputs do.
- R8: While `rst_n` is low, `sum` and `cout` are zero.
- R9: A `sum` that contains 1110 or 1111 digits, fed back as an operand, gives a correct R2 total. For example, 9742 + 5954 gives 156F6, and adding 04192 to that gives 19888.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the result register |
| a | input | 4*DIGITS | First operand, extended decimal digits, digit 0 in bits 3:0 |
| b | input | 4*DIGITS | Second operand, same layout |
| cin | input | 1 | Decimal carry into digit 0 |
| sum | output | 4*DIGITS | Registered extended-code sum |
| cout | output | 1 | Registered decimal carry out of the top digit |

## Verification
The assertions assume that every operand digit presented with `en` high lies in the legal code set of R1. The clocked input check and the digit cell's result checks rest on that. The stimulus builds each digit from an index over the twelve legal codes, so no illegal code is ever driven. With two digits per operand, every pair of legal operands is swept against both carry-in values. A five-digit instance then runs the chained example, where redundant codes appear at the input.

// File: rtl/bcdx_pkg.sv
package bcdx_pkg;
  localparam int unsigned NIB = 4;
  localparam logic [3:0] CORR = 4'd6;

  function automatic logic legal_code(input logic [3:0] d);
    return (d <= 4'd9) || (d >= 4'd14);
  endfunction

  function automatic logic [3:0] to_plain(input logic [3:0] d);
    return (d[3] & d[2] & d[1]) ? {d[3], 2'b00, d[0]} : d;
  endfunction
endpackage

// File: rtl/bcdx_digit_cell.sv
module bcdx_digit_cell
  import bcdx_pkg::*;
(
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       ci,
  output logic [3:0] z,
  output logic       co
);
  logic       pre_add;
  logic       x_red, y_red;
  logic [3:0] xn, yn;
  logic [4:0] wide;

  // Pre-correction decided from the upper three bits of the raw codes
  assign pre_add = x[3] | y[3] | (x[2] & y[2]) | ((x[2] | y[2]) & x[1] & y[1]);

  // A redundant 1110/1111 code carries an implicit +6; remove it
  assign x_red = x[3] & x[2] & x[1];
  assign y_red = y[3] & y[2] & y[1];
  assign xn    = x_red ? {x[3], 2'b00, x[0]} : x;
  assign yn    = y_red ? {y[3], 2'b00, y[0]} : y;

  assign wide = {1'b0, xn} + {1'b0, yn} + {4'b0, ci} + {1'b0, (pre_add ? CORR : 4'd0)};
  assign z    = wide[3:0];
  assign co   = wide[4];

  always_comb begin
    if (!$isunknown({x, y, ci}) && legal_code(x) && legal_code(y)) begin
      // R5: a digit that carries out is left in plain code
      a_r5_carry_plain: assert (!co || z <= 4'd9);
      // R4: a redundant result code only when the plain upper parts sum to 8
      a_r4_redundant_only_at_8: assert (z < 4'd14 ||
        ({1'b0, to_plain(x) & 4'b1110} + {1'b0, to_plain(y) & 4'b1110}) == 5'd8);
      // R3: the result is a legal extended code
      a_r3_cell_legal: assert (legal_code(z));
    end
  end
endmodule

// File: rtl/bcdx_ripple.sv
module bcdx_ripple #(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [DIGITS:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcdx_digit_cell u_cell (
      .x  (a[4*g +: 4]),
      .y  (b[4*g +: 4]),
      .ci (carry[g]),
      .z  (s[4*g +: 4]),
      .co (carry[g+1])
    );
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/bcdx_adder.sv
module bcdx_adder
  import bcdx_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] add_s;
  logic         add_c;
  logic [W-1:0] sum_d, sum_q;
  logic         cout_d, cout_q;

  bcdx_ripple #(.DIGITS(DIGITS)) u_ripple (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .s    (add_s),
    .cout (add_c)
  );

  always_comb begin
    sum_d  = sum_q;
    cout_d = cout_q;
    if (en) begin
      sum_d  = add_s;
      cout_d = add_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

  assign sum  = sum_q;
  assign cout = cout_q;

  // R7: the result register holds while the enable is low
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sum_q) && $stable(cout_q)));

  // R8: reset clears the result
  always_ff @(posedge clk) begin
    if (!rst_n) a_r8_reset_clear: assert (sum_q == '0 && !cout_q);
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    // R1: operands carry only legal extended codes when loaded
    a_r1_input_legal: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (legal_code(a[4*g +: 4]) && legal_code(b[4*g +: 4])));
    // R3: every stored digit is a legal extended code
    a_r3_output_legal: assert property (@(posedge clk) disable iff (!rst_n)
      legal_code(sum_q[4*g +: 4]));
  end
endmodule

// File: tb/bcdx_adder_tb.sv
module bcdx_adder_tb;
  localparam int unsigned ND = 2;
  localparam int unsigned NW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [4*ND-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [4*ND-1:0] sum;
  logic cout;

  logic wen = 1'b0;
  logic [4*NW-1:0] wa = '0, wb = '0;
  logic wcin = 1'b0;
  logic [4*NW-1:0] wsum;
  logic wcout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcdx_adder #(.DIGITS(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .a(a), .b(b), .cin(cin),
    .sum(sum), .cout(cout));

  bcdx_adder #(.DIGITS(NW)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .en(wen), .a(wa), .b(wb), .cin(wcin),
    .sum(wsum), .cout(wcout));

  function automatic int dval(input int n);
    return (n >= 14) ? n - 6 : n;
  endfunction

  function automatic logic [3:0] code_of(input int k);
    return (k < 10) ? 4'(k) : 4'(k + 4);
  endfunction

  function automatic longint decode(input logic [4*NW-1:0] v, input int nd);
    longint acc = 0;
    for (int i = nd - 1; i >= 0; i--) acc = acc * 10 + dval(int'(v[4*i +: 4]));
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R8: reset state
    check(sum == '0 && cout == 1'b0, "R8 reset sum", longint'(sum), 0);
    check(wsum == '0 && wcout == 1'b0, "R8 reset wide", longint'(wsum), 0);
    rst_n = 1'b1;
    tick();
    check(sum == '0 && cout == 1'b0, "R8 idle after release", longint'(sum), 0);

    // Exhaustive sweep over legal two-digit operands (R1 codes only)
    for (int i = 0; i < 144; i++) begin
      for (int j = 0; j < 144; j++) begin
        for (int c = 0; c < 2; c++) begin
          logic [3:0] a0, a1, b0, b1;
          int t0, t1, c1, c2, n0, n1, u0, u1;
          longint exp, act;
          a0 = code_of(i % 12); a1 = code_of(i / 12);
          b0 = code_of(j % 12); b1 = code_of(j / 12);
          a = {a1, a0}; b = {b1, b0}; cin = c[0]; en = 1'b1;
          tick();
          t0 = dval(int'(a0)) + dval(int'(b0)) + c;
          c1 = (t0 >= 10) ? 1 : 0;
          t1 = dval(int'(a1)) + dval(int'(b1)) + c1;
          c2 = (t1 >= 10) ? 1 : 0;
          exp = longint'(dval(int'(a1)) * 10 + dval(int'(a0))
                       + dval(int'(b1)) * 10 + dval(int'(b0)) + c);
          act = longint'(cout) * 100 + decode({12'b0, sum}, ND);
          check(act == exp, "R2 decoded total", act, exp);
          n0 = int'(sum[3:0]); n1 = int'(sum[7:4]);
          check((n0 <= 9 || n0 >= 14) && (n1 <= 9 || n1 >= 14),
                "R3 legal output codes", longint'(sum), exp);
          u0 = (dval(int'(a0)) & 14) + (dval(int'(b0)) & 14);
          u1 = (dval(int'(a1)) & 14) + (dval(int'(b1)) & 14);
          check((n0 < 14 || u0 == 8) && (n1 < 14 || u1 == 8),
                "R4 redundant code only at upper sum 8", longint'(sum), exp);
          check((c1 == 0 || n0 <= 9) && (c2 == 0 || n1 <= 9),
                "R5 carrying digit is plain", longint'(sum), exp);
        end
      end
    end

    // R6: carry runs the full length
    a = 8'h99; b = 8'h00; cin = 1'b1; en = 1'b1;
    tick();
    check(sum == 8'h00 && cout == 1'b1, "R6 full ripple", longint'({cout, sum}), 'h100);
    a = 8'hFF; b = 8'h00; cin = 1'b1;
    tick();
    check(sum == 8'h00 && cout == 1'b1, "R6 full ripple redundant nines",
          longint'({cout, sum}), 'h100);

    // R7: hold while enable is low
    a = 8'h12; b = 8'h34; cin = 1'b0; en = 1'b1;
    tick();
    en = 1'b0; a = 8'h98; b = 8'h76; cin = 1'b1;
    tick();
    tick();
    check(sum == 8'h46 && cout == 1'b0, "R7 hold with enable low", longint'(sum), 'h46);
    en = 1'b1;
    tick();
    check(cout == 1'b1 && decode({12'b0, sum}, ND) == 75, "R7 load after hold",
          longint'(sum), 75);

    // R9: chained example through the wide instance
    wa = 20'h09742; wb = 20'h05954; wcin = 1'b0; wen = 1'b1;
    tick();
    check(wsum == 20'h156F6 && wcout == 1'b0, "R9 first level raw", longint'(wsum), 'h156F6);
    check(decode(wsum, NW) == 15696, "R9 first level value", decode(wsum, NW), 15696);
    wa = wsum; wb = 20'h04192;
    tick();
    check(wcout == 1'b0 && decode(wsum, NW) == 19888, "R9 second level value",
          decode(wsum, NW), 19888);
    wen = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule